// File: doc/BRIEF.md
# Serial Bus Slave Address Match Unit

This block sits on the receive side of a clocked serial bus slave. Serial bits arrive one per shift strobe and enter an 8-bit shift register, most significant bit first. When a byte marked as an address byte completes, the block compares it with an address register that software loads with the slave's own number. The result drives three outputs: a coincidence status bit, a bus-release flag, and a serial interrupt request.

The bus-release flag is set by a release-condition input and is cleared when an address byte does not match, so software can tell whether a released bus was then claimed by another slave. With wake-up enabled, the interrupt fires only on an address match, so a sleeping slave wakes only when it is addressed. With wake-up disabled, every completed byte raises it. After reset the block is in halt mode: the shifter refuses bits and the shift register becomes a plain byte register that software can load and read.

The serial input is a valid/ready stream of single bits. A bit is taken on a clock edge where `bit_valid` and `bit_ready` are both high. `bit_ready` is high exactly while the run bit is set, so in halt mode the block applies back-pressure and every bit offered is left untaken. The sender may insert idle cycles between bits at will. A byte is only counted once its eighth bit has been taken.

Top module: `sbus_addr_match`

## Requirements
- R1: After reset the control readback `ctl_q` is 00h (halt mode, wake-up off, coincidence 0), `bit_ready` is 0, and `shreg_q`, `reld` and `irq_flag` are 0.
- R2: While the run bit (`ctl_q[7]`) is 0, `bit_ready` is 0 and offered bits leave `shreg_q` unchanged, and a `shreg_wr` loads `shreg_wdata` into `shreg_q` on the next edge. While the run bit is 1, `shreg_wr` has no effect.
- R3: In run mode each taken bit shifts into bit 0 and moves the older bits up, so after eight taken bits `shreg_q` equals the byte sent MSB first. Idle cycles between bits do not change the result.
- R4: A byte whose eighth bit is taken with `bit_addr`=1 and that equals the address register sets the coincidence bit `ctl_q[6]` two clock edges after the eighth bit is taken.
- R5: An address byte that differs from the address register clears `reld` in that same cycle, and the coincidence bit stays 0. A matching address byte leaves `reld` unchanged.
- R6: A `bus_rel` pulse in run mode sets `reld`. `reld_clr` clears it, and the clear wins over a `bus_rel` in the same cycle. `bus_rel` is ignored in halt mode.
- R7: With wake-up enabled (`ctl_q[5]`=1), `irq_pulse` fires only for a matching address byte: never for a mismatch and never for a data byte.
- R8: With wake-up disabled, `irq_pulse` fires for every completed byte, two edges after its eighth bit is taken, whether it is an address byte or a data byte, matching or not.
- R9: `irq_pulse` lasts one cycle and sets `irq_flag` in the same cycle. `irq_flag` stays set until `irq_clr`, and a new request wins over an `irq_clr` in the same cycle.
- R10: The coincidence bit clears on the edge that takes the first bit of the next byte, and on any control register write. Bit 6 of the written value is ignored.
- R11: A byte completed with `bit_addr`=0 does not set the coincidence bit and does not change `reld`, even when its value equals the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value: bit 7 run, bit 5 wake-up enable |
| ctl_q | output | 8 | Control readback: bit 7 run, bit 6 coincidence, bit 5 wake-up |
| sva_wr | input | 1 | Slave address register write strobe |
| sva_wdata | input | 8 | Slave address value |
| shreg_wr | input | 1 | Shift register direct write (halt mode only) |
| shreg_wdata | input | 8 | Shift register direct write value |
| shreg_q | output | 8 | Shift register contents |
| bit_valid | input | 1 | Serial bit offered (shift strobe) |
| bit_ready | output | 1 | Block accepts bits (run mode) |
| bit_data | input | 1 | Serial bit value |
| bit_addr | input | 1 | Marks the current byte as an address byte |
| bus_rel | input | 1 | Bus-release condition detected |
| reld_clr | input | 1 | Software clear of the bus-release flag |
| reld | output | 1 | Bus-release detection flag |
| irq_clr | input | 1 | Software clear of the interrupt request flag |
| irq_pulse | output | 1 | One-cycle serial interrupt request |
| irq_flag | output | 1 | Sticky interrupt request flag |

## Verification
A bit counter that slips by one position shows at the ports on the very next byte: the completion and its interrupt come one strobe early or late, and `shreg_q` holds a rotated value at the checked cycle. A coincidence or bus-release bit left in the wrong state shows two edges after the eighth bit, in `ctl_q[6]` or `reld`. It then stays wrong until the next byte starts, so checks placed in that window catch it. A wrong wake-up gate shows as an extra or missing `irq_pulse` in the same cycle, and it leaves a sticky `irq_flag` that persists until it is cleared.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int CTL_W    = 8;
  localparam int CTL_RUN  = 7;
  localparam int CTL_COI  = 6;
  localparam int CTL_WAKE = 5;

  typedef struct packed {
    logic run;
    logic wake;
  } sam_mode_t;
endpackage

// File: rtl/sam_shifter.sv
module sam_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          bit_valid,
  input  logic          bit_data,
  input  logic          bit_addr,
  input  logic          sw_wr,
  input  logic [DW-1:0] sw_data,
  output logic          bit_ready,
  output logic [DW-1:0] shreg,
  output logic          start,
  output logic          done,
  output logic          done_addr
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic          take;
  logic          last;

  assign bit_ready = run;
  assign take      = bit_valid & run;
  assign last      = (cnt == LAST);
  assign start     = take & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      done      <= 1'b0;
      done_addr <= 1'b0;
    end else begin
      done      <= take & last;
      done_addr <= take & last & bit_addr;
      if (!run) begin
        cnt <= '0;
        if (sw_wr) shreg <= sw_data;
      end else if (take) begin
        shreg <= {shreg[DW-2:0], bit_data};
        cnt   <= last ? '0 : cnt + CW'(1);
      end
    end
  end

  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_wr) |=> (shreg == $past(shreg)));
  assert_done_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run));
  assert_addr_is_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_addr |-> done);
endmodule

// File: rtl/sam_compare.sv
module sam_compare #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          done,
  input  logic          done_addr,
  input  logic          start,
  input  logic          ctl_wr,
  input  logic [DW-1:0] shreg,
  input  logic [DW-1:0] sva,
  input  logic          bus_rel,
  input  logic          reld_clr,
  output logic          hit,
  output logic          coi,
  output logic          reld
);
  logic miss;

  assign hit  = done_addr & (shreg == sva);
  assign miss = done_addr & (shreg != sva);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coi  <= 1'b0;
      reld <= 1'b0;
    end else begin
      if (hit)                 coi <= 1'b1;
      else if (ctl_wr || start) coi <= 1'b0;
      if (miss || reld_clr)    reld <= 1'b0;
      else if (bus_rel && run) reld <= 1'b1;
    end
  end

  assert_hit_sets_coi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> coi);
  assert_miss_clears_reld_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_addr && !hit) |=> !reld);
  assert_data_keeps_coi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_addr && !start && !ctl_wr) |=> (coi == $past(coi)));
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reld_clr |=> !reld);
endmodule

// File: rtl/sam_irq.sv
module sam_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic hit,
  input  logic wake,
  input  logic irq_clr,
  output logic irq_pulse,
  output logic irq_flag
);
  logic fire;

  assign fire = done & (wake ? hit : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (fire)         irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  assert_flag_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_flag);
  assert_wake_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wake && !hit) |=> !irq_pulse);
  assert_every_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wake) |=> irq_pulse);
endmodule

// File: rtl/sbus_addr_match.sv
module sbus_addr_match
  import sam_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             sva_wr,
  input  logic [DW-1:0]    sva_wdata,
  input  logic             shreg_wr,
  input  logic [DW-1:0]    shreg_wdata,
  output logic [DW-1:0]    shreg_q,
  input  logic             bit_valid,
  output logic             bit_ready,
  input  logic             bit_data,
  input  logic             bit_addr,
  input  logic             bus_rel,
  input  logic             reld_clr,
  output logic             reld,
  input  logic             irq_clr,
  output logic             irq_pulse,
  output logic             irq_flag
);
  sam_mode_t     mode;
  logic [DW-1:0] sva;
  logic          start, done, done_addr, hit, coi;
  logic          unused_wbits;

  assign unused_wbits = ^{ctl_wdata[CTL_COI], ctl_wdata[CTL_WAKE-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      sva  <= '0;
    end else begin
      if (ctl_wr) begin
        mode.run  <= ctl_wdata[CTL_RUN];
        mode.wake <= ctl_wdata[CTL_WAKE];
      end
      if (sva_wr) sva <= sva_wdata;
    end
  end

  always_comb begin
    ctl_q           = '0;
    ctl_q[CTL_RUN]  = mode.run;
    ctl_q[CTL_COI]  = coi;
    ctl_q[CTL_WAKE] = mode.wake;
  end

  sam_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(mode.run),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_addr(bit_addr),
    .sw_wr(shreg_wr), .sw_data(shreg_wdata),
    .bit_ready(bit_ready), .shreg(shreg_q),
    .start(start), .done(done), .done_addr(done_addr)
  );

  sam_compare #(.DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .run(mode.run),
    .done(done), .done_addr(done_addr), .start(start), .ctl_wr(ctl_wr),
    .shreg(shreg_q), .sva(sva), .bus_rel(bus_rel), .reld_clr(reld_clr),
    .hit(hit), .coi(coi), .reld(reld)
  );

  sam_irq u_irq (
    .clk(clk), .rst_n(rst_n), .done(done), .hit(hit), .wake(mode.wake),
    .irq_clr(irq_clr), .irq_pulse(irq_pulse), .irq_flag(irq_flag)
  );

  assert_ready_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[CTL_RUN]) |=> !bit_ready);
  assert_ctl_wr_clears_coi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !hit) |=> !ctl_q[CTL_COI]);
endmodule

// File: tb/sim_sbus_addr_match.sv
module sim_sbus_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, sva_wr = 0, shreg_wr = 0;
  logic [7:0] ctl_wdata = 0, sva_wdata = 0, shreg_wdata = 0;
  logic [7:0] ctl_q, shreg_q;
  logic bit_valid = 0, bit_data = 0, bit_addr = 0;
  logic bus_rel = 0, reld_clr = 0, irq_clr = 0;
  logic bit_ready, reld, irq_pulse, irq_flag;
  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  sbus_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .sva_wr(sva_wr), .sva_wdata(sva_wdata), .shreg_wr(shreg_wr),
    .shreg_wdata(shreg_wdata), .shreg_q(shreg_q), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_data(bit_data), .bit_addr(bit_addr),
    .bus_rel(bus_rel), .reld_clr(reld_clr), .reld(reld), .irq_clr(irq_clr),
    .irq_pulse(irq_pulse), .irq_flag(irq_flag)
  );

  function automatic logic exp_fire(logic wake, logic is_addr, logic match);
    return wake ? (is_addr & match) : 1'b1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0;
  endtask

  task automatic wr_sva(logic [7:0] v);
    sva_wr = 1; sva_wdata = v; tick(); sva_wr = 0;
  endtask

  task automatic pulse_rel();
    bus_rel = 1; tick(); bus_rel = 0;
  endtask

  task automatic clr_irq();
    irq_clr = 1; tick(); irq_clr = 0;
  endtask

  // Leaves time just after the edge that follows the eighth taken bit.
  task automatic send_byte(logic [7:0] b, logic a, int maxgap);
    for (int i = 0; i < 8; i++) begin
      int g;
      g = (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0;
      repeat (g) tick();
      bit_valid = 1; bit_data = b[7-i]; bit_addr = a;
      tick();
      bit_valid = 0;
      if (i == 0) chk("R10 coi cleared at first bit", ctl_q[6], 0);
    end
    chk("R3 shift contents", shreg_q, b);
    tick();
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic r_wake, r_addr, r_match, e_reld;
    logic [7:0] r_sva, r_byte;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 ctl reset", ctl_q, 8'h00);
    chk("R1 ready reset", bit_ready, 0);
    chk("R1 shreg reset", shreg_q, 0);
    chk("R1 reld reset", reld, 0);
    chk("R1 irq reset", irq_flag, 0);

    // Halt mode
    bit_valid = 1; bit_data = 1; tick(); tick(); bit_valid = 0;
    chk("R2 halt no shift", shreg_q, 0);
    chk("R2 halt ready low", bit_ready, 0);
    pulse_rel();
    chk("R6 bus_rel ignored in halt", reld, 0);
    shreg_wr = 1; shreg_wdata = 8'hA5; tick(); shreg_wr = 0;
    chk("R2 halt direct write", shreg_q, 8'hA5);
    wr_ctl(8'h80);
    chk("R2 ready in run", bit_ready, 1);
    shreg_wr = 1; shreg_wdata = 8'h3C; tick(); shreg_wr = 0;
    chk("R2 write ignored in run", shreg_q, 8'hA5);

    // Directed: wake-up on, match
    wr_sva(8'h5A);
    wr_ctl(8'hA0);
    pulse_rel();
    chk("R6 reld set", reld, 1);
    send_byte(8'h5A, 1, 0);
    chk("R4 coi on match", ctl_q[6], 1);
    chk("R5 reld kept on match", reld, 1);
    chk("R7 irq on match", irq_pulse, 1);
    chk("R9 flag set", irq_flag, 1);
    tick();
    chk("R9 pulse one cycle", irq_pulse, 0);
    chk("R9 flag sticky", irq_flag, 1);
    clr_irq();
    chk("R9 flag cleared", irq_flag, 0);
    wr_ctl(8'hE0);
    chk("R10 ctl write clears coi", ctl_q, 8'hA0);

    // Mismatch
    send_byte(8'h5A, 1, 0);
    chk("R4 coi again", ctl_q[6], 1);
    send_byte(8'h5B, 1, 2);
    chk("R5 coi stays 0 on mismatch", ctl_q[6], 0);
    chk("R5 reld cleared on mismatch", reld, 0);
    chk("R7 no irq on mismatch", irq_pulse, 0);
    clr_irq();

    // Data byte equal to address
    pulse_rel();
    send_byte(8'h5A, 0, 1);
    chk("R11 data no coi", ctl_q[6], 0);
    chk("R11 data keeps reld", reld, 1);
    chk("R7 no irq on data", irq_pulse, 0);

    // reld clear priority
    bus_rel = 1; reld_clr = 1; tick(); bus_rel = 0; reld_clr = 0;
    chk("R6 clear wins", reld, 0);

    // Wake-up off: irq every byte, set wins over clear
    wr_ctl(8'h80);
    irq_clr = 1;
    send_byte(8'h11, 0, 0);
    chk("R8 irq on data byte", irq_pulse, 1);
    chk("R9 set wins over clear", irq_flag, 1);
    irq_clr = 0;
    clr_irq();

    // Random
    e_reld = reld;
    r_sva = 8'h5A;
    for (int it = 0; it < 80; it++) begin
      if ($urandom % 4 == 0) begin
        r_sva = 8'($urandom);
        wr_sva(r_sva);
      end
      r_wake = 1'($urandom);
      wr_ctl({1'b1, 1'b0, r_wake, 5'b0});
      if ($urandom % 2 == 1) begin
        pulse_rel();
        e_reld = 1;
      end
      r_addr = 1'($urandom);
      r_byte = ($urandom % 2 == 1) ? r_sva : 8'($urandom);
      r_match = (r_byte == r_sva);
      send_byte(r_byte, r_addr, 2);
      if (r_addr && !r_match) e_reld = 0;
      chk("R4 R11 random coi", ctl_q[6], r_addr & r_match);
      chk("R5 R6 random reld", reld, e_reld);
      chk(r_wake ? "R7 random irq" : "R8 random irq", irq_pulse,
          exp_fire(r_wake, r_addr, r_match));
      clr_irq();
      chk("R9 random flag clear", irq_flag, 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule